// File: doc/BRIEF.md
# Configuration Port Unlock Decoder

This block implements the plug-and-play configuration front end of a peripheral controller. It sits on a simple byte-wide I/O bus and, in reset, stays locked. While locked, the only thing it does is watch the byte writes to its base port for a four-byte unlock key. Once the whole key has been seen, the base port becomes an index register and the port one above it becomes a data register. Together they reach a few global registers and one bank of registers per logical device. A logical device number held in the global space picks which bank is reached.

A small state machine does the key matching. Its states are `ST_WAIT_K0`, `ST_WAIT_K1`, `ST_WAIT_K2`, `ST_WAIT_K3` and `ST_OPEN`:

- **Advance:** a key byte that matches the expected one moves the machine from each `ST_WAIT_Kn` to the next state. From `ST_WAIT_K3`, it moves to `ST_OPEN`.
- **Restart:** a byte that does not match sends the machine back to `ST_WAIT_K0`.
- **Fresh start:** a mismatched byte equal to the first key byte sends the machine to `ST_WAIT_K1` instead.
- **Exit:** the exit command moves the machine from `ST_OPEN` back to `ST_WAIT_K0`.

The register file provides the device activate bits, the input clock selection and the software-suspend control as outputs.

Top module: `cfgp_unlock_decoder`

## Requirements
- R1: After reset the block is locked. `cfg_unlocked` is 0, `dev_active` is all zero, and `clk_sel_24m` is 0, meaning the 48 MHz input. `soft_suspend` is 0, and reads of either port return 0xFF.
- R2: Writing 0x87, 0x01, 0x55 and then a last byte, in that order, to `BASE_ADDR` unlocks the block. The last byte is 0x55 when `BASE_ADDR` is 0x2E and 0xAA when it is 0x4E. `cfg_unlocked` rises on the clock edge that takes the last byte.
- R3: During the key, a byte written to `BASE_ADDR` that is not the expected one restarts matching. If that byte is 0x87, it counts as a new first byte.
- R4: While the block is locked, writes to `BASE_ADDR`+1 change no register. Reads of both ports return 0xFF.
- R5: While the block is unlocked, a write to `BASE_ADDR` loads the index register, and a read of `BASE_ADDR` returns it. Accesses to `BASE_ADDR`+1 reach the register that the index selects.
- R6: Global index 0x07 holds the 8-bit logical device number. It can be written and read back.
- R7: Index 0x30 is the activate register of the bank that the logical device number selects. Bit 0 drives `dev_active[ldn]`, and a read returns {7'b0, bit}. When the device number is `NUM_DEV` or higher, writes are ignored and reads return 0x00.
- R8: Bit 0 of global index 0x23 drives `clk_sel_24m`, where 1 selects 24 MHz. The register reads back as {7'b0, bit}.
- R9: Bit 0 of global index 0x24 drives `soft_suspend`. The register reads back as {7'b0, bit}.
- R10: Writing 0x02 to global index 0x02 relocks the block on that edge and clears the index register. Any other value written there has no effect, and a read of index 0x02 returns 0x00.
- R11: Indices with no register read 0x00, and writes to them change nothing.
- R12: Writes to addresses other than the two ports are ignored. `io_rdata` is 0xFF whenever `io_rd` is low or the address is neither port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_addr | input | AW | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from address and state |
| cfg_unlocked | output | 1 | High while configuration access is open |
| dev_active | output | NUM_DEV | Activate bit per logical device |
| clk_sel_24m | output | 1 | 1 selects the 24 MHz input clock, 0 the 48 MHz input clock |
| soft_suspend | output | 1 | Software-suspend control |

## Verification
The assertions assume the following about the inputs:
- A high `io_wr` for one cycle is exactly one byte transfer.
- `io_wr` and `io_rd` are never high together.
- Address and data are stable around the sampling edge.

The bench meets these assumptions by issuing a single operation at a time. It changes the inputs on the falling edge and drops the strobe after one rising edge. The random stimulus favours key bytes while the block is locked, and the meaningful indices and the exit value while it is open. This keeps the block crossing between the locked and open states often, which the assertions on the state machine and the register file depend on seeing.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_K0,
        ST_WAIT_K1,
        ST_WAIT_K2,
        ST_WAIT_K3,
        ST_OPEN
    } cfgp_state_e;

    localparam logic [7:0] KEY_B0     = 8'h87;
    localparam logic [7:0] KEY_B1     = 8'h01;
    localparam logic [7:0] KEY_B2     = 8'h55;

    localparam logic [7:0] IDX_CC     = 8'h02;
    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_CLKSEL = 8'h23;
    localparam logic [7:0] IDX_SUSP   = 8'h24;
    localparam logic [7:0] IDX_ACT    = 8'h30;
    localparam logic [7:0] CC_EXIT    = 8'h02;

    localparam logic [7:0] BUS_IDLE   = 8'hFF;

endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
    import cfgp_pkg::*;
#(
    parameter logic [7:0] KEY_LAST = 8'h55
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [7:0]  key_byte,
    input  logic        exit_req,
    output logic        open_o
);

    cfgp_state_e state_q, state_d;
    cfgp_state_e restart_st;

    // A mismatch that is itself the first key byte starts a new attempt
    always_comb begin
        restart_st = (key_byte == KEY_B0) ? ST_WAIT_K1 : ST_WAIT_K0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_K0: if (key_wr) state_d = restart_st;
            ST_WAIT_K1: if (key_wr) state_d = (key_byte == KEY_B1)   ? ST_WAIT_K2 : restart_st;
            ST_WAIT_K2: if (key_wr) state_d = (key_byte == KEY_B2)   ? ST_WAIT_K3 : restart_st;
            ST_WAIT_K3: if (key_wr) state_d = (key_byte == KEY_LAST) ? ST_OPEN    : restart_st;
            ST_OPEN:    if (exit_req) state_d = ST_WAIT_K0;
            default:    state_d = ST_WAIT_K0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_K0;
        else        state_q <= state_d;
    end

    always_comb begin
        open_o = (state_q == ST_OPEN);
    end

    a_r2_last_byte_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_K3 && key_wr && key_byte == KEY_LAST) |=> open_o);

    a_r3_first_byte_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_K1 && key_wr && key_byte == KEY_B0) |=> (state_q == ST_WAIT_K1));

    a_r3_mismatch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_K2 && key_wr && key_byte != KEY_B2 && key_byte != KEY_B0)
        |=> (state_q == ST_WAIT_K0));

    a_r10_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && exit_req) |=> !open_o);

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr && !exit_req) |=> $stable(state_q));

endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
    import cfgp_pkg::*;
#(
    parameter int NUM_DEV = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open_i,
    input  logic               idx_wr,
    input  logic               dat_wr,
    input  logic [7:0]         wdata,
    output logic               exit_req,
    output logic [7:0]         idx_rd,
    output logic [7:0]         dat_rd,
    output logic [NUM_DEV-1:0] dev_active,
    output logic               clk_sel_24m,
    output logic               soft_suspend
);

    logic [7:0]         idx_q;
    logic [7:0]         ldn_q;
    logic               clk_sel_q;
    logic               susp_q;
    logic [NUM_DEV-1:0] act_q;
    logic               act_rd;
    logic               dat_we;

    always_comb begin
        dat_we   = open_i && dat_wr;
        exit_req = dat_we && (idx_q == IDX_CC) && (wdata == CC_EXIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
        end else if (exit_req) begin
            idx_q <= 8'h00;
        end else if (open_i && idx_wr) begin
            idx_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ldn_q     <= 8'h00;
            clk_sel_q <= 1'b0;
            susp_q    <= 1'b0;
        end else if (dat_we) begin
            if (idx_q == IDX_LDN)    ldn_q     <= wdata;
            if (idx_q == IDX_CLKSEL) clk_sel_q <= wdata[0];
            if (idx_q == IDX_SUSP)   susp_q    <= wdata[0];
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_q[d] <= 1'b0;
            end else if (dat_we && idx_q == IDX_ACT && ldn_q == 8'(d)) begin
                act_q[d] <= wdata[0];
            end
        end

        a_r7_activate_write: assert property (@(posedge clk) disable iff (!rst_n)
            (open_i && dat_wr && idx_q == IDX_ACT && ldn_q == 8'(d))
            |=> (dev_active[d] == $past(wdata[0])));
    end

    always_comb begin
        act_rd = 1'b0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (ldn_q == 8'(d)) act_rd = act_q[d];
        end
    end

    always_comb begin
        idx_rd = idx_q;
        case (idx_q)
            IDX_LDN:    dat_rd = ldn_q;
            IDX_CLKSEL: dat_rd = {7'b0, clk_sel_q};
            IDX_SUSP:   dat_rd = {7'b0, susp_q};
            IDX_ACT:    dat_rd = {7'b0, act_rd};
            default:    dat_rd = 8'h00;
        endcase
    end

    always_comb begin
        dev_active   = act_q;
        clk_sel_24m  = clk_sel_q;
        soft_suspend = susp_q;
    end

    a_r4_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> ($stable(ldn_q) && $stable(clk_sel_24m) && $stable(soft_suspend)
                     && $stable(dev_active)));

    a_r8_clock_select: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && dat_wr && idx_q == IDX_CLKSEL) |=> (clk_sel_24m == $past(wdata[0])));

    a_r10_index_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> (idx_rd == 8'h00));

endmodule

// File: rtl/cfgp_unlock_decoder.sv
module cfgp_unlock_decoder
    import cfgp_pkg::*;
#(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   BASE_ADDR = AW'(16'h002E),
    parameter int              NUM_DEV   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [AW-1:0]      io_addr,
    input  logic [7:0]         io_wdata,
    output logic [7:0]         io_rdata,
    output logic               cfg_unlocked,
    output logic [NUM_DEV-1:0] dev_active,
    output logic               clk_sel_24m,
    output logic               soft_suspend
);

    localparam logic [AW-1:0] DATA_ADDR = BASE_ADDR + AW'(1);
    localparam logic [7:0]    KEY_LAST  = (BASE_ADDR == AW'(16'h004E)) ? 8'hAA : 8'h55;

    logic       hit_base, hit_data;
    logic       exit_req;
    logic       open_w;
    logic [7:0] idx_rd, dat_rd;

    always_comb begin
        hit_base = (io_addr == BASE_ADDR);
        hit_data = (io_addr == DATA_ADDR);
    end

    cfgp_key_fsm #(
        .KEY_LAST (KEY_LAST)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (io_wr && hit_base),
        .key_byte (io_wdata),
        .exit_req (exit_req),
        .open_o   (open_w)
    );

    cfgp_regs #(
        .NUM_DEV (NUM_DEV)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .open_i       (open_w),
        .idx_wr       (io_wr && hit_base),
        .dat_wr       (io_wr && hit_data),
        .wdata        (io_wdata),
        .exit_req     (exit_req),
        .idx_rd       (idx_rd),
        .dat_rd       (dat_rd),
        .dev_active   (dev_active),
        .clk_sel_24m  (clk_sel_24m),
        .soft_suspend (soft_suspend)
    );

    always_comb begin
        cfg_unlocked = open_w;
        io_rdata     = BUS_IDLE;
        if (io_rd && open_w) begin
            if (hit_base)      io_rdata = idx_rd;
            else if (hit_data) io_rdata = dat_rd;
        end
    end

    a_r4_locked_reads_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked && io_rd) |-> (io_rdata == BUS_IDLE));

    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_rd));

endmodule

// File: tb/cfgp_unlock_decoder_bench.sv
`timescale 1ns/1ps
module cfgp_unlock_decoder_bench;

    localparam int          AW   = 16;
    localparam logic [15:0] BASE = 16'h002E;
    localparam logic [15:0] DATP = BASE + 16'd1;
    localparam int          NDEV = 8;
    localparam logic [7:0]  LAST = (BASE == 16'h004E) ? 8'hAA : 8'h55;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            io_wr = 1'b0;
    logic            io_rd = 1'b0;
    logic [AW-1:0]   io_addr = '0;
    logic [7:0]      io_wdata = '0;
    logic [7:0]      io_rdata;
    logic            cfg_unlocked;
    logic [NDEV-1:0] dev_active;
    logic            clk_sel_24m;
    logic            soft_suspend;

    int n_tests = 0;
    int n_fail  = 0;

    int          m_stage;
    logic [7:0]  m_idx, m_ldn;
    logic [NDEV-1:0] m_act;
    logic        m_clk, m_susp;

    always #2.5 clk = ~clk;

    cfgp_unlock_decoder #(
        .AW        (AW),
        .BASE_ADDR (BASE),
        .NUM_DEV   (NDEV)
    ) u_cfgp_unlock_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .io_wr        (io_wr),
        .io_rd        (io_rd),
        .io_addr      (io_addr),
        .io_wdata     (io_wdata),
        .io_rdata     (io_rdata),
        .cfg_unlocked (cfg_unlocked),
        .dev_active   (dev_active),
        .clk_sel_24m  (clk_sel_24m),
        .soft_suspend (soft_suspend)
    );

    function automatic logic [7:0] key_at(input int s);
        case (s)
            0:       return 8'h87;
            1:       return 8'h01;
            2:       return 8'h55;
            default: return LAST;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (a != BASE && a != DATP) return 8'hFF;
        if (m_stage != 4)           return 8'hFF;
        if (a == BASE)              return m_idx;
        case (m_idx)
            8'h07:   return m_ldn;
            8'h23:   return {7'b0, m_clk};
            8'h24:   return {7'b0, m_susp};
            8'h30:   return (m_ldn < NDEV) ? {7'b0, m_act[m_ldn[2:0]]} : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_stage = 0; m_idx = 0; m_ldn = 0; m_act = '0; m_clk = 0; m_susp = 0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (m_stage < 4) begin
            if (a == BASE) begin
                if (d == key_at(m_stage)) m_stage = m_stage + 1;
                else if (d == 8'h87)      m_stage = 1;
                else                      m_stage = 0;
            end
        end else if (a == BASE) begin
            m_idx = d;
        end else if (a == DATP) begin
            case (m_idx)
                8'h07: m_ldn = d;
                8'h02: if (d == 8'h02) begin m_stage = 0; m_idx = 0; end
                8'h23: m_clk = d[0];
                8'h24: m_susp = d[0];
                8'h30: if (m_ldn < NDEV) m_act[m_ldn[2:0]] = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_check(input logic [15:0] a, input string req);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1;
        check({24'b0, io_rdata}, {24'b0, exp_read(a)}, req, "read");
        io_rd = 1'b0;
    endtask

    task automatic outs_check(input string req);
        check({31'b0, cfg_unlocked}, {31'b0, m_stage == 4}, req, "unlocked");
        check({24'b0, dev_active}, {24'b0, m_act}, req, "dev_active");
        check({30'b0, clk_sel_24m, soft_suspend}, {30'b0, m_clk, m_susp}, req, "clk/susp");
    endtask

    task automatic unlock();
        for (int s = 0; s < 4; s++) wr(BASE, key_at(s));
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
        wr(BASE, idx);
        wr(DATP, val);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        outs_check("R1");
        rd_check(BASE, "R1");
        rd_check(DATP, "R1");

        // R4 locked: data writes ignored, reads idle
        wr(DATP, 8'h01);
        wr(DATP, 8'hFF);
        outs_check("R4");
        rd_check(DATP, "R4");

        // R2 full key
        unlock();
        check({31'b0, cfg_unlocked}, 32'd1, "R2", "unlocked after key");

        // R5 / R6 index and device number
        set_reg(8'h07, 8'h03);
        rd_check(BASE, "R5");
        rd_check(DATP, "R6");

        // R7 activate bits
        set_reg(8'h30, 8'h01);
        outs_check("R7");
        rd_check(DATP, "R7");
        set_reg(8'h07, 8'h09);
        set_reg(8'h30, 8'h01);
        outs_check("R7");
        rd_check(DATP, "R7");

        // R8 / R9 clock select and suspend
        set_reg(8'h23, 8'h01);
        rd_check(DATP, "R8");
        set_reg(8'h24, 8'h01);
        rd_check(DATP, "R9");
        outs_check("R8");

        // R11 unused index
        set_reg(8'h55, 8'h5A);
        rd_check(DATP, "R11");
        outs_check("R11");

        // R12 other address and idle read
        wr(DATP + 16'd1, 8'h00);
        rd_check(DATP + 16'd1, "R12");
        outs_check("R12");

        // R10 exit command
        set_reg(8'h02, 8'h05);
        rd_check(DATP, "R10");
        check({31'b0, cfg_unlocked}, 32'd1, "R10", "non-exit value");
        wr(DATP, 8'h02);
        check({31'b0, cfg_unlocked}, 32'd0, "R10", "relocked");
        rd_check(BASE, "R10");

        // R3 restarts inside the key
        wr(BASE, 8'h87); wr(BASE, 8'h01); wr(BASE, 8'h87);
        wr(BASE, 8'h01); wr(BASE, 8'h55); wr(BASE, LAST);
        check({31'b0, cfg_unlocked}, 32'd1, "R3", "0x87 restart");
        set_reg(8'h02, 8'h02);
        wr(BASE, 8'h87); wr(BASE, 8'h01); wr(BASE, 8'h55); wr(BASE, 8'h13);
        check({31'b0, cfg_unlocked}, 32'd0, "R3", "bad last byte");
        wr(BASE, 8'h87); wr(BASE, 8'h87); wr(BASE, 8'h01); wr(BASE, 8'h55); wr(BASE, LAST);
        check({31'b0, cfg_unlocked}, 32'd1, "R3", "repeated first byte");
        rd_check(BASE, "R5");

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [15:0] a;
            logic [7:0]  d;
            r = $urandom_range(0, 99);
            if (r < 45)      a = BASE;
            else if (r < 90) a = DATP;
            else             a = BASE + 16'd2;
            d = 8'($urandom);
            if (a == BASE) begin
                if (m_stage < 4) begin
                    if ($urandom_range(0, 3) != 0) d = key_at(m_stage);
                    else if ($urandom_range(0, 1) == 0) d = 8'h87;
                end else begin
                    case ($urandom_range(0, 5))
                        0: d = 8'h02;
                        1: d = 8'h07;
                        2: d = 8'h23;
                        3: d = 8'h24;
                        4: d = 8'h30;
                        default: ;
                    endcase
                end
            end else if (a == DATP) begin
                if (m_idx == 8'h02 && $urandom_range(0, 4) == 0) d = 8'h02;
                if (m_idx == 8'h07) d = 8'($urandom_range(0, NDEV + 2));
            end
            if ($urandom_range(0, 9) < 7) wr(a, d);
            else rd_check(a, "R5");
            if (i % 8 == 0) outs_check("R7");
        end
        outs_check("R2");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule